// File: doc/BRIEF.md
# Register-Mapped SPI Master Core

This core is a single-chip-select SPI master driven through a small register window. Software writes a control word to choose the word length (4 to 32 bits), clock polarity, clock phase, internal loopback and a held chip select, and then writes words into the data register. Each written word is handed to an external TX queue. When the port is enabled, the core pops words from that queue and shifts them out MSB first on `mosi`. In the same frame it shifts in the same number of bits from `miso`, or from its own `mosi` in loopback, and pushes each received word into an external RX queue. Reading the data register pops that queue. The queue storage, thresholds and interrupts live in a neighbouring block, and the core reaches them only through push/pop strobes.

The serial clock has no divider. Each pulse of `sclk_en` moves the serial clock by one half-period, so one bit takes two pulses. A four-state machine runs the frame. `ST_IDLE` pops a word when the port is enabled and TX data is waiting (transition *load*). `ST_LOW` holds the clock at its idle level until a tick produces the leading edge (transition *lead*). `ST_HIGH` holds the clock at its active level until a tick produces the trailing edge. That edge returns to `ST_LOW` (transition *next bit*), or to `ST_DONE` after the last bit (transition *last bit*). `ST_DONE` pushes the received word and returns to `ST_IDLE` (transition *retire*).

Register offsets: control at 0x00, data at 0x10, status at 0x14.

Top module: `spi_master_core`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, status reads 0 and control reads 0.
- R2: The control register layout is: enable in bit 0, frame format in bits 2:1, word length minus one in bits 9:5, polarity in bit 10, phase in bit 11, loopback in bit 12 and chip-select hold in bit 14. The frame format field is only stored, and value 0 (Motorola) is the only format shifted. Any other bit reads 0, so writing 0xFFFFFFFF reads back 0x00005FE7.
- R3: The word length is the length field plus one. A field value below 3 is treated as a length of 4. Only the low word-length bits of a TX entry are sent, MSB first.
- R4: Every transmitted word pushes exactly one RX word. RX words are pushed in order, right-aligned and zero-extended to 32 bits.
- R5: Whenever no word is in flight, `sclk` sits at the polarity bit: 0 when the bit is clear, 1 when it is set.
- R6: With phase 0, `mosi` is valid before the leading edge, `miso` is sampled on the leading edge, and `mosi` changes on the trailing edge. With phase 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R7: In loopback, the received word equals the transmitted word and `miso` is ignored.
- R8: `cs_n` is the inverse of control bit 14, whatever the state of the enable bit.
- R9: While enable is 0, no word is popped from TX. Clearing enable in the middle of a word lets that word finish, and no further word starts.
- R10: While enabled with the TX queue empty, the core sends no filler word, keeps the clock idle and pushes nothing to RX.
- R11: Status bit 0 (busy) is 1 while a word is in flight, or while enable is 1 and TX is not empty. Otherwise it is 0.
- R12: A bus write to 0x10 strobes `tx_wr_en` with the written data. A bus read from 0x10 strobes `rx_rd_en` and returns `rx_rd_data`.
- R13: `sclk` changes only in the cycle after an `sclk_en` pulse, one edge per pulse, so a word of N bits shows 2N edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_en | input | 1 | Half-period tick for the serial clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tx_wr_en | output | 1 | Push strobe to the TX queue |
| tx_wr_data | output | 32 | Word pushed to the TX queue |
| tx_empty | input | 1 | TX queue holds no word |
| tx_rd_en | output | 1 | Pop strobe to the TX queue |
| tx_rd_data | input | 32 | Head of the TX queue |
| rx_wr_en | output | 1 | Push strobe to the RX queue |
| rx_wr_data | output | 32 | Received word, right-aligned |
| rx_rd_en | output | 1 | Pop strobe to the RX queue |
| rx_rd_data | input | 32 | Head of the RX queue |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A control-register write that clears the enable bit can land while the engine is still in the middle of a word, and the engine can finish that word with more TX data waiting. The bench queues two words, enables the port and clears enable a few cycles into the first word. It then judges that exactly one RX word appears, with the first word's value, and that the second word is still queued with busy low. Re-enabling must then drain the leftover word in order. A second collision is a polarity change with the clock idle. That clock change has no tick behind it, so the tick-to-edge rule is judged only while the polarity bit is steady.

// File: rtl/spi_core_pkg.sv
`timescale 1ns/1ps
package spi_core_pkg;

    localparam logic [4:0] ADDR_CTRL = 5'h00;
    localparam logic [4:0] ADDR_DATA = 5'h10;
    localparam logic [4:0] ADDR_STAT = 5'h14;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } shift_state_e;

    typedef struct packed {
        logic       hold_cs;
        logic       loopback;
        logic       cpha;
        logic       cpol;
        logic [4:0] len_m1;
        logic [1:0] fmt;
        logic       enable;
    } ctrl_t;

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        return {17'd0, c.hold_cs, 1'b0, c.loopback, c.cpha, c.cpol,
                c.len_m1, 2'b00, c.fmt, c.enable};
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.enable   = w[0];
        c.fmt      = w[2:1];
        c.len_m1   = w[9:5];
        c.cpol     = w[10];
        c.cpha     = w[11];
        c.loopback = w[12];
        c.hold_cs  = w[14];
        return c;
    endfunction

endpackage

// File: rtl/spi_reg_file.sv
`timescale 1ns/1ps
module spi_reg_file
    import spi_core_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5,
    localparam int LEN_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic             busy,
    output logic             tx_wr_en,
    output logic [W-1:0]     tx_wr_data,
    output logic             rx_rd_en,
    input  logic [W-1:0]     rx_rd_data,
    output logic             enable,
    output logic [LEN_W-1:0] len_m1,
    output logic             cpol,
    output logic             cpha,
    output logic             loopback,
    output logic             hold_cs
);

    ctrl_t ctrl_q;
    logic  wr_acc, rd_acc;

    assign wr_acc = bus_sel & bus_wr;
    assign rd_acc = bus_sel & ~bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_acc && bus_addr == AW'(ADDR_CTRL)) begin
            ctrl_q <= ctrl_unpack(bus_wdata);
        end
    end

    assign tx_wr_en   = wr_acc && (bus_addr == AW'(ADDR_DATA));
    assign tx_wr_data = bus_wdata;
    assign rx_rd_en   = rd_acc && (bus_addr == AW'(ADDR_DATA));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_CTRL))      bus_rdata = W'(ctrl_pack(ctrl_q));
        else if (bus_addr == AW'(ADDR_DATA)) bus_rdata = rx_rd_data;
        else if (bus_addr == AW'(ADDR_STAT)) bus_rdata = W'(busy);
    end

    assign enable   = ctrl_q.enable;
    assign len_m1   = LEN_W'(ctrl_q.len_m1);
    assign cpol     = ctrl_q.cpol;
    assign cpha     = ctrl_q.cpha;
    assign loopback = ctrl_q.loopback;
    assign hold_cs  = ctrl_q.hold_cs;

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == AW'(ADDR_CTRL)) |=>
            (hold_cs == $past(bus_wdata[14]) && enable == $past(bus_wdata[0])));

endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_core_pkg::*;
#(
    parameter int W = 32,
    localparam int LEN_W = $clog2(W),
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_en,
    input  logic             enable,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             loopback,
    input  logic             tx_empty,
    input  logic [W-1:0]     tx_rd_data,
    output logic             tx_rd_en,
    output logic             rx_wr_en,
    output logic [W-1:0]     rx_wr_data,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             active
);

    shift_state_e     state_q, state_d;
    logic [W-1:0]     tx_sh, rx_sh;
    logic [CNT_W-1:0] bits_left, word_len;
    logic             first_bit, rx_bit;

    assign word_len = (len_m1 < LEN_W'(3)) ? CNT_W'(4)
                                           : CNT_W'(len_m1) + CNT_W'(1);
    assign rx_bit   = loopback ? tx_sh[W-1] : miso;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tx_rd_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && !tx_empty) begin
                    tx_rd_en = 1'b1;
                    state_d  = ST_LOW;
                end
            end
            ST_LOW:  if (sclk_en) state_d = ST_HIGH;
            ST_HIGH: if (sclk_en) state_d = (bits_left == CNT_W'(1)) ? ST_DONE : ST_LOW;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sclk       = cpol ^ (state_q == ST_HIGH);
        mosi       = tx_sh[W-1];
        rx_wr_en   = (state_q == ST_DONE);
        rx_wr_data = rx_sh;
        active     = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            first_bit <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (tx_rd_en) begin
                        tx_sh     <= tx_rd_data << (CNT_W'(W) - word_len);
                        rx_sh     <= '0;
                        bits_left <= word_len;
                        first_bit <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (sclk_en) begin
                        first_bit <= 1'b0;
                        if (cpha && !first_bit) tx_sh <= tx_sh << 1;
                        if (!cpha)              rx_sh <= {rx_sh[W-2:0], rx_bit};
                    end
                end
                ST_HIGH: begin
                    if (sclk_en) begin
                        bits_left <= bits_left - CNT_W'(1);
                        if (cpha) rx_sh <= {rx_sh[W-2:0], rx_bit};
                        else      tx_sh <= tx_sh << 1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R13
    sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sclk) && $stable(cpol)) |-> $past(sclk_en));

    // R9
    pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd_en |=> !tx_rd_en);

    // R4
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en |=> (!rx_wr_en && !active));

endmodule

// File: rtl/spi_master_core.sv
`timescale 1ns/1ps
module spi_master_core #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_en,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          tx_wr_en,
    output logic [W-1:0]  tx_wr_data,
    input  logic          tx_empty,
    output logic          tx_rd_en,
    input  logic [W-1:0]  tx_rd_data,
    output logic          rx_wr_en,
    output logic [W-1:0]  rx_wr_data,
    output logic          rx_rd_en,
    input  logic [W-1:0]  rx_rd_data,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);

    localparam int LEN_W = $clog2(W);

    logic             enable, cpol, cpha, loopback, hold_cs;
    logic [LEN_W-1:0] len_m1;
    logic             eng_active, busy;

    assign busy = eng_active | (enable & ~tx_empty);
    assign cs_n = ~hold_cs;

    spi_reg_file #(.W(W), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .tx_wr_en   (tx_wr_en),
        .tx_wr_data (tx_wr_data),
        .rx_rd_en   (rx_rd_en),
        .rx_rd_data (rx_rd_data),
        .enable     (enable),
        .len_m1     (len_m1),
        .cpol       (cpol),
        .cpha       (cpha),
        .loopback   (loopback),
        .hold_cs    (hold_cs)
    );

    spi_shift_engine #(.W(W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_en    (sclk_en),
        .enable     (enable),
        .len_m1     (len_m1),
        .cpol       (cpol),
        .cpha       (cpha),
        .loopback   (loopback),
        .tx_empty   (tx_empty),
        .tx_rd_data (tx_rd_data),
        .tx_rd_en   (tx_rd_en),
        .rx_wr_en   (rx_wr_en),
        .rx_wr_data (rx_wr_data),
        .miso       (miso),
        .sclk       (sclk),
        .mosi       (mosi),
        .active     (eng_active)
    );

    // R5
    idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

endmodule

// File: tb/sim_spi_master_core.sv
`timescale 1ns/1ps
module sim_spi_master_core;

    typedef struct packed {
        logic [4:0]  lenf;
        logic        cpol;
        logic        cpha;
        logic        loop;
        logic [31:0] tx;
        logic [31:0] slv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{5'd7,  1'b0, 1'b0, 1'b0, 32'h000000A5, 32'h0000003C},
        '{5'd7,  1'b1, 1'b1, 1'b0, 32'h0000005A, 32'h000000C3},
        '{5'd3,  1'b0, 1'b1, 1'b0, 32'h000000F9, 32'h00000006},
        '{5'd31, 1'b1, 1'b0, 1'b0, 32'hDEADBEEF, 32'h12345678},
        '{5'd15, 1'b0, 1'b0, 1'b1, 32'hBEEF1234, 32'h0000FFFF},
        '{5'd11, 1'b1, 1'b1, 1'b1, 32'h00000ABC, 32'h00000000},
        '{5'd1,  1'b0, 1'b1, 1'b0, 32'h000000F5, 32'h00000003}
    };

    logic clk = 1'b0, rst_n = 1'b0, sclk_en = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic tx_wr_en, tx_rd_en, rx_wr_en, rx_rd_en, tx_empty;
    logic [31:0] tx_wr_data, tx_rd_data, rx_wr_data, rx_rd_data;
    logic sclk, mosi, miso = 1'b0, cs_n;

    logic [31:0] txq [16], rxq [16];
    logic [3:0]  tx_head = '0, rx_head = '0;
    logic [4:0]  tx_cnt = '0, rx_cnt = '0;

    logic [31:0] slv_sh = '0, cap = '0;
    int          cap_n = 0, edge_n = 0;
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0, prev_sclk = 1'b0;

    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    spi_master_core u0 (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_empty(tx_empty),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    assign tx_empty   = (tx_cnt == 5'd0);
    assign tx_rd_data = txq[tx_head];
    assign rx_rd_data = (rx_cnt == 5'd0) ? 32'd0 : rxq[rx_head];

    // queue models of the neighbouring storage block
    initial forever begin
        @(posedge clk);
        if (tx_wr_en) txq[tx_head + tx_cnt[3:0]] <= tx_wr_data;
        if (tx_rd_en) tx_head <= tx_head + 4'd1;
        tx_cnt <= tx_cnt + {4'd0, tx_wr_en} - {4'd0, tx_rd_en};
        if (rx_wr_en) rxq[rx_head + rx_cnt[3:0]] <= rx_wr_data;
        if (rx_rd_en) rx_head <= rx_head + 4'd1;
        rx_cnt <= rx_cnt + {4'd0, rx_wr_en} - {4'd0, rx_rd_en};
    end

    // tick every other cycle
    initial forever begin
        @(negedge clk);
        sclk_en = ~sclk_en;
    end

    // slave model: capture mosi on sample edges, move miso after them
    initial forever begin
        @(negedge clk);
        if (!cs_n && sclk !== prev_sclk) begin
            edge_n++;
            if ((prev_sclk == cur_cpol) ^ cur_cpha) begin
                cap    = {cap[30:0], mosi};
                cap_n++;
                slv_sh = slv_sh << 1;
            end
        end
        prev_sclk = sclk;
        miso      = slv_sh[31];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int k = 0;
        while (int'(rx_cnt) < n && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic en, input logic [4:0] lenf,
        input logic pol, input logic pha, input logic lp, input logic hold);
        return {17'd0, hold, 1'b0, lp, pha, pol, lenf, 4'd0, en};
    endfunction

    function automatic int len_of(input logic [4:0] lenf);
        return (lenf < 5'd3) ? 4 : int'(lenf) + 1;
    endfunction

    function automatic logic [31:0] mask_of(input int len);
        return (len == 32) ? 32'hFFFFFFFF : ((32'd1 << len) - 32'd1);
    endfunction

    task automatic run_vec(input vec_t v);
        int          len;
        logic [31:0] m, rd;
        len = len_of(v.lenf);
        m   = mask_of(len);
        bus_write(8'h00, mk_ctrl(1'b0, v.lenf, v.cpol, v.cpha, v.loop, 1'b0));
        repeat (2) @(negedge clk);
        cur_cpol = v.cpol; cur_cpha = v.cpha;
        slv_sh = v.slv << (32 - len);
        cap = '0; cap_n = 0; edge_n = 0;
        bus_write(8'h00, mk_ctrl(1'b1, v.lenf, v.cpol, v.cpha, v.loop, 1'b1));
        check("R8 cs_n held low", {31'd0, cs_n}, 32'd0);
        bus_write(8'h10, v.tx);
        wait_rx(1);
        check("R4 one RX word per TX word", {27'd0, rx_cnt}, 32'd1);
        bus_read(8'h10, rd);
        check(v.loop ? "R7 loopback RX word" : "R4 R6 RX word from miso", rd,
              v.loop ? (v.tx & m) : (v.slv & m));
        check("R3 R6 bits seen on mosi", cap, v.tx & m);
        check("R3 bit count", cap_n, len);
        check("R13 edges per word", edge_n, 2 * len);
        check("R5 idle clock level", {31'd0, sclk}, {31'd0, v.cpol});
        bus_write(8'h00, mk_ctrl(1'b0, v.lenf, v.cpol, v.cpha, v.loop, 1'b0));
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n after reset", {31'd0, cs_n}, 32'd1);
        check("R1 sclk after reset", {31'd0, sclk}, 32'd0);
        bus_read(5'h14, rd); check("R1 status after reset", rd, 32'd0);
        bus_read(5'h00, rd); check("R1 control after reset", rd, 32'd0);

        // R2 layout and read-back
        bus_write(5'h00, 32'hFFFFFFFF);
        bus_read(5'h00, rd); check("R2 control read-back", rd, 32'h00005FE7);
        bus_write(5'h00, 32'h0);

        // R8 chip select independent of enable
        bus_write(5'h00, 32'h00004000);
        check("R8 cs_n low with enable off", {31'd0, cs_n}, 32'd0);
        bus_write(5'h00, 32'h0);
        check("R8 cs_n released", {31'd0, cs_n}, 32'd1);

        // vector table
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10 stall on empty TX
        cur_cpol = 1'b1; cur_cpha = 1'b0; edge_n = 0;
        bus_write(5'h00, mk_ctrl(1'b0, 5'd7, 1'b1, 1'b0, 1'b1, 1'b0));
        bus_write(5'h00, mk_ctrl(1'b1, 5'd7, 1'b1, 1'b0, 1'b1, 1'b1));
        repeat (40) @(negedge clk);
        check("R10 no edges while TX empty", edge_n, 0);
        check("R10 no RX push while TX empty", {27'd0, rx_cnt}, 32'd0);
        bus_read(5'h14, rd); check("R11 idle busy", rd, 32'd0);

        // R9 disabled port does not pop
        cur_cpol = 1'b0;
        bus_write(5'h00, mk_ctrl(1'b0, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1));
        bus_write(5'h10, 32'h00000011);
        check("R12 data write pushes TX", {27'd0, tx_cnt}, 32'd1);
        repeat (40) @(negedge clk);
        check("R9 no pop while disabled", {27'd0, tx_cnt}, 32'd1);
        bus_read(5'h14, rd); check("R11 busy low while disabled", rd, 32'd0);
        bus_write(5'h00, mk_ctrl(1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (4) @(negedge clk);
        bus_read(5'h14, rd); check("R11 busy during word", rd, 32'd1);
        wait_rx(1);
        bus_read(5'h10, rd); check("R12 data read pops RX", rd, 32'h00000011);
        check("R12 RX queue drained", {27'd0, rx_cnt}, 32'd0);

        // R9 disable in mid-word
        bus_write(5'h00, mk_ctrl(1'b0, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1));
        bus_write(5'h10, 32'h000000C7);
        bus_write(5'h10, 32'h0000002E);
        bus_write(5'h00, mk_ctrl(1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (6) @(negedge clk);
        bus_write(5'h00, mk_ctrl(1'b0, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (120) @(negedge clk);
        check("R9 current word finishes", {27'd0, rx_cnt}, 32'd1);
        check("R9 next word not started", {27'd0, tx_cnt}, 32'd1);
        bus_read(5'h14, rd); check("R11 busy low after stop", rd, 32'd0);
        bus_read(5'h10, rd); check("R9 finished word value", rd, 32'h000000C7);
        bus_write(5'h00, mk_ctrl(1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1));
        wait_rx(1);
        bus_read(5'h10, rd); check("R4 leftover word after re-enable", rd, 32'h0000002E);

        // R4 back-to-back order
        bus_write(5'h00, mk_ctrl(1'b0, 5'd4, 1'b0, 1'b1, 1'b1, 1'b1));
        bus_write(5'h10, 32'h00000013);
        bus_write(5'h10, 32'hFFFFFF2A);
        bus_write(5'h10, 32'h00000001);
        bus_write(5'h00, mk_ctrl(1'b1, 5'd4, 1'b0, 1'b1, 1'b1, 1'b1));
        wait_rx(3);
        check("R4 three RX words", {27'd0, rx_cnt}, 32'd3);
        bus_read(5'h10, rd); check("R4 order word 0", rd, 32'h00000013);
        bus_read(5'h10, rd); check("R4 order word 1 zero-extended", rd, 32'h0000000A);
        bus_read(5'h10, rd); check("R4 order word 2", rd, 32'h00000001);
        bus_write(5'h00, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule